// File: doc/BRIEF.md
# Serial Control-Latch Shifter

This block holds an eight-bit board control word in a shadow register and copies it into an external serial-in, parallel-out latch whenever asked. It drives three open lines: a clock and a data line that are also used by a two-wire (I2C-style) bus master elsewhere on the board, and a dedicated strobe line that moves the shifted bits onto the latch outputs. Software-side logic changes single bits through set and clear masks and then raises an update request; a grant input says when the shared lines may be taken.

Every line change is held for a fixed number of system clock cycles before the next one. When a transfer ends, the clock and data lines are both left high, so the other bus master can issue a START condition at once. Update requests that arrive during a transfer are folded into a single follow-up transfer that carries the newest word.

Top module: `board_ctrl_shifter`

## Requirements
- R1: While reset is asserted and afterwards until a transfer begins, scl=1, sda=1, str=0 and busy=0; reset loads the shadow word with 0xCC (bit 7 EEPROM write control, active low; bit 6 PCI reset, active low; bit 3 port 1 DTR, active low; bit 2 port 0 DTR, active low; bit 5 auto-reset, bit 4 external control, bit 1 port 1 internal clock and bit 0 port 0 internal clock all 0) and marks one transfer as pending.
- R2: Each cycle the shadow word becomes (word AND NOT clr_mask) OR set_mask, so set wins where both masks have a bit; mask changes alone start no transfer.
- R3: A transfer starts only while busy=0, a transfer is pending and grant=1; with grant=0 a pending transfer waits for as long as grant stays low.
- R4: The word captured at the start of a transfer is sent most significant bit first; for each bit scl goes low, then sda takes the bit, then scl rises, and the bit is valid on that rising edge.
- R5: After the eighth rising clock edge str is driven high and then low; then scl goes low, sda goes high and scl goes high, ending with scl=1, sda=1, str=0.
- R6: During a transfer every level on scl, sda and str is held at least HOLD_CYC system clock cycles before the next change.
- R7: Update requests that arrive while busy=1 produce exactly one further transfer, carrying the shadow word as it stands when that transfer starts.
- R8: busy is high for exactly 29*HOLD_CYC cycles per transfer, rising with the first scl fall; sda never changes while scl is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_mask | input | 8 | Bits to force to 1 in the shadow word this cycle |
| clr_mask | input | 8 | Bits to force to 0 in the shadow word this cycle |
| update_req | input | 1 | Request a copy of the shadow word to the latch |
| grant | input | 1 | Shared clock/data lines may be taken |
| scl | output | 1 | Shift clock, shared with the two-wire bus |
| sda | output | 1 | Shift data, shared with the two-wire bus |
| str | output | 1 | Latch strobe |
| busy | output | 1 | Transfer in progress |

## Verification
The hardest situation to reach is a burst of updates landing while a transfer is already running, since it must collapse into one extra transfer carrying the final word. The stimulus raises an update, waits for busy, then issues two further mask-and-update requests mid-transfer and confirms that exactly two words reach the latch and that the second holds both changes. Holding grant low with a request pending, and a last data bit of 1 that leaves sda unchanged in the closing sequence, are driven on purpose as well.

// File: rtl/board_ctrl_shifter.sv
module board_ctrl_shifter #(
  parameter int                WORD_W    = 8,
  parameter int                HOLD_CYC  = 150,
  parameter logic [WORD_W-1:0] INIT_WORD = 8'hCC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] set_mask,
  input  logic [WORD_W-1:0] clr_mask,
  input  logic              update_req,
  input  logic              grant,
  output logic              scl,
  output logic              sda,
  output logic              str,
  output logic              busy
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam int BW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [HW-1:0] RELOAD = HW'(HOLD_CYC - 1);
  localparam logic [BW-1:0] LASTB  = BW'(WORD_W - 1);

  logic [WORD_W-1:0] shadow, snap;
  logic              pending;
  logic [BW-1:0]     bidx;
  logic [1:0]        sub;
  logic              tail;
  logic [2:0]        tidx;
  logic [HW-1:0]     cnt;

  wire [WORD_W-1:0] shadow_nx = (shadow & ~clr_mask) | set_mask;
  wire start = !busy && pending && grant;
  wire last  = tail && (tidx == 3'd4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow  <= INIT_WORD;
      pending <= 1'b1;
      busy    <= 1'b0;
      snap    <= '0;
      bidx    <= '0;
      sub     <= 2'd0;
      tail    <= 1'b0;
      tidx    <= 3'd0;
      cnt     <= '0;
      scl     <= 1'b1;
      sda     <= 1'b1;
      str     <= 1'b0;
    end else begin
      shadow <= shadow_nx;
      if (update_req)  pending <= 1'b1;
      else if (start)  pending <= 1'b0;

      if (start) begin
        busy <= 1'b1;
        snap <= shadow;
        bidx <= '0;
        sub  <= 2'd0;
        tail <= 1'b0;
        tidx <= 3'd0;
        cnt  <= RELOAD;
        scl  <= 1'b0;
      end else if (busy) begin
        if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else if (last) begin
          busy <= 1'b0;
        end else begin
          cnt <= RELOAD;
          if (!tail) begin
            case (sub)
              2'd0: begin
                sub <= 2'd1;
                sda <= snap[WORD_W-1];
              end
              2'd1: begin
                sub <= 2'd2;
                scl <= 1'b1;
              end
              default: begin
                sub  <= 2'd0;
                snap <= snap << 1;
                if (bidx == LASTB) begin
                  tail <= 1'b1;
                  tidx <= 3'd0;
                  str  <= 1'b1;
                end else begin
                  bidx <= bidx + 1'b1;
                  scl  <= 1'b0;
                end
              end
            endcase
          end else begin
            tidx <= tidx + 3'd1;
            case (tidx)
              3'd0:    str <= 1'b0;
              3'd1:    scl <= 1'b0;
              3'd2:    sda <= 1'b1;
              default: scl <= 1'b1;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/board_ctrl_shifter_chk.sv
module board_ctrl_shifter_chk #(
  parameter int HOLD_CYC = 150
) (
  input logic clk,
  input logic rst_n,
  input logic grant,
  input logic scl,
  input logic sda,
  input logic str,
  input logic busy
);
  localparam int GW = $clog2(HOLD_CYC + 1) + 1;
  localparam logic [GW-1:0] GMAX = GW'(HOLD_CYC);

  logic [2:0]    prev_lines;
  logic [GW-1:0] gap;
  wire chg = {scl, sda, str} != prev_lines;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_lines <= 3'b110;
      gap        <= GMAX;
    end else begin
      prev_lines <= {scl, sda, str};
      if (chg)              gap <= GW'(1);
      else if (gap != GMAX) gap <= gap + 1'b1;
    end
  end

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (scl && sda && !str)); // R5
  AST_GRANT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(grant)); // R3
  AST_START_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !scl); // R8
  AST_SDA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl && $past(scl)) |-> $stable(sda)); // R8
  AST_STROBE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(str) |-> scl); // R5
  AST_HOLD_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    (chg && busy) |-> (gap >= GMAX)); // R6
endmodule

bind board_ctrl_shifter board_ctrl_shifter_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .grant(grant),
  .scl(scl), .sda(sda), .str(str), .busy(busy)
);

// File: tb/sim_board_ctrl_shifter.sv
module sim_board_ctrl_shifter;
  localparam int H = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       upd = 1'b0;
  logic       grant = 1'b0;
  logic [7:0] setm = 8'h00;
  logic [7:0] clrm = 8'h00;
  logic       scl, sda, str, busy;

  board_ctrl_shifter #(.WORD_W(8), .HOLD_CYC(H), .INIT_WORD(8'hCC)) u0 (
    .clk(clk), .rst_n(rst_n), .set_mask(setm), .clr_mask(clrm),
    .update_req(upd), .grant(grant),
    .scl(scl), .sda(sda), .str(str), .busy(busy)
  );

  always #10 clk = ~clk;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  logic [2:0] pl;
  int         gap, nbits, bcnt;
  logic [7:0] sh;
  bit         str_seen, tail_fall, pbusy;
  logic [7:0] words [0:31];
  int         nx = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      pl = 3'b110; gap = 1000; nbits = 0; bcnt = 0; pbusy = 0;
      str_seen = 0; tail_fall = 0; sh = 8'h00;
    end else begin
      if ({scl, sda, str} != pl) begin
        if (busy) chk(gap >= H, "R6", "hold cycles", gap, H);
        gap = 1;
      end else gap = gap + 1;
      if (busy && !pbusy) begin
        nbits = 0; str_seen = 0; tail_fall = 0; bcnt = 0;
      end
      if (busy) bcnt++;
      if (scl && !pl[2] && busy && !str_seen) begin
        sh = {sh[6:0], sda};
        nbits++;
      end
      if (scl && pl[2] && (pl[1] != sda))
        chk(0, "R8", "sda moved while scl high", sda, pl[1]);
      if (str && !pl[0]) begin
        chk(nbits == 8, "R4", "bits before strobe", nbits, 8);
        chk(scl == 1'b1, "R5", "scl at strobe", scl, 1);
        words[nx % 32] = sh;
        nx++;
        str_seen = 1;
      end
      if (!scl && pl[2] && str_seen && !str) tail_fall = 1;
      if (!busy && pbusy) begin
        chk({scl, sda, str} == 3'b110, "R5", "lines after transfer",
            {scl, sda, str}, 3'b110);
        chk(tail_fall, "R5", "clock dropped after strobe", tail_fall, 1);
        chk(bcnt == 29 * H, "R8", "busy length", bcnt, 29 * H);
      end
      pl = {scl, sda, str};
      pbusy = busy;
    end
  end

  task automatic req(input logic [7:0] s, input logic [7:0] c, input logic u);
    @(negedge clk);
    setm = s; clrm = c; upd = u;
    @(negedge clk);
    setm = 8'h00; clrm = 8'h00; upd = 1'b0;
  endtask

  task automatic wait_xfers(input int n);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (nx >= n && !busy) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; grant = 1'b0;
    repeat (4) @(negedge clk);
    chk({scl, sda, str, busy} == 4'b1100, "R1", "lines in reset",
        {scl, sda, str, busy}, 4'b1100);
    rst_n = 1'b1;
    repeat (60) @(negedge clk);
    chk(busy == 1'b0 && nx == 0, "R3", "no start without grant", nx, 0);
    chk({scl, sda, str} == 3'b110, "R1", "idle lines after reset",
        {scl, sda, str}, 3'b110);
    grant = 1'b1;
    wait_xfers(1);
    chk(nx == 1, "R1", "reset transfer count", nx, 1);
    chk(words[0] == 8'hCC, "R1", "reset word", words[0], 8'hCC);
  endtask

  task automatic t_set_clear;
    req(8'h01, 8'h00, 1'b1);
    wait_xfers(2);
    chk(words[1] == 8'hCD, "R2", "set bit 0", words[1], 8'hCD);
    req(8'h00, 8'h80, 1'b1);
    wait_xfers(3);
    chk(words[2] == 8'h4D, "R2", "clear bit 7", words[2], 8'h4D);
    req(8'h10, 8'h10, 1'b1);
    wait_xfers(4);
    chk(words[3] == 8'h5D, "R2", "set wins over clear", words[3], 8'h5D);
  endtask

  task automatic t_no_update;
    req(8'h20, 8'h00, 1'b0);
    repeat (300) @(negedge clk);
    chk(nx == 4 && !busy, "R2", "mask alone starts nothing", nx, 4);
    req(8'h00, 8'h00, 1'b1);
    wait_xfers(5);
    chk(words[4] == 8'h7D, "R2", "held mask sent later", words[4], 8'h7D);
  endtask

  task automatic t_pending;
    req(8'h00, 8'h00, 1'b1);
    for (int i = 0; i < 50 && !busy; i++) @(negedge clk);
    req(8'h02, 8'h00, 1'b1);
    req(8'h00, 8'h40, 1'b1);
    wait_xfers(7);
    repeat (400) @(negedge clk);
    chk(nx == 7, "R7", "one follow-up transfer", nx, 7);
    chk(words[5] == 8'h7D, "R7", "word at first start", words[5], 8'h7D);
    chk(words[6] == 8'h3F, "R7", "merged follow-up word", words[6], 8'h3F);
  endtask

  task automatic t_grant;
    grant = 1'b0;
    req(8'h00, 8'h00, 1'b1);
    repeat (300) @(negedge clk);
    chk(nx == 7 && !busy, "R3", "held off by grant", nx, 7);
    chk({scl, sda, str} == 3'b110, "R3", "lines idle while waiting",
        {scl, sda, str}, 3'b110);
    grant = 1'b1;
    wait_xfers(8);
    chk(words[7] == 8'h3F, "R3", "sent after grant", words[7], 8'h3F);
  endtask

  task automatic t_patterns;
    req(8'hAA, 8'h55, 1'b1);
    wait_xfers(9);
    chk(words[8] == 8'hAA, "R4", "pattern AA", words[8], 8'hAA);
    req(8'h55, 8'hAA, 1'b1);
    wait_xfers(10);
    chk(words[9] == 8'h55, "R4", "pattern 55 msb first", words[9], 8'h55);
  endtask

  initial begin
    t_reset();
    t_set_clear();
    t_no_update();
    t_pending();
    t_grant();
    t_patterns();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(0, "WDOG", "watchdog expired", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule